// File: doc/BRIEF.md
# RAM/ROM overlay selector

This block sits beside a processor whose option RAM board shares address space with the system ROMs. For every memory cycle it decides whether the option RAM or the ROMs answer. The decision uses the cycle qualifiers from the processor's monitor bus, the read/write direction, the address, and the region of the instruction now executing. A sixteen-entry map holds one bit per 4K region of the address space: 1 means option RAM and 0 means ROM. A configuration port loads the map for bring-up and test.

The RAM/ROM decision is combinational. It settles from inputs that are stable before the memory cycle starts. Only two things are registers: the map, and a small tracker that records the region and source of the last instruction fetch. The block also produces an active-low option-present line and two ROM window enables, which are only granted when the option board is fitted and ROM is selected.

Top module: `ovl_sel`

## Requirements
- R1: After reset the map holds MAP_RST (default 0x00F0, regions 4 to 7 mapped to RAM), and the instruction tracker records no ROM-resident instruction.
- R2: When cfg_we_i is high at a rising clock edge, map entry cfg_idx_i takes cfg_val_i from that edge on. A data read at a lower-half address outside the exclusion then asserts ram_en_o and deasserts rom_sel_o exactly when the entry of region addr_i[15:12] is 1.
- R3: Addresses below 0x0800 never enable option RAM, whatever the map holds, so rom_sel_o stays high.
- R4: Upper-half addresses (addr_i[15]=1) never enable option RAM.
- R5: I/O cycles never enable option RAM.
- R6: RAM is enabled only in a valid memory cycle, meaning mem_valid_i is high and cpu_q_i or mon_q_i is high. Otherwise ram_en_o is low and rom_sel_o is high.
- R7: Writes follow the map alone. A write to a region mapped to ROM leaves ram_en_o low, so the write is ignored.
- R8: A valid instruction fetch that is served from ROM in the lower half records its region. A later data read into that same region is served by ROM even when the map says RAM. An instruction fetch served by RAM, or fetched from the upper half, clears this record.
- R9: Instruction and address fetches follow the map bit.
- R10: With opt_fit_i low, opt_n_o is high and ram_en_o, prog_rom_en_o and cart_en_o are low. With opt_fit_i high, opt_n_o is low.
- R11: prog_rom_en_o is high only for 0x5000 to 0x53FF, and only while the option is fitted and rom_sel_o is high.
- R12: cart_en_o is high only for 0x5400 to 0x5FFF, and only while the option is fitted and rom_sel_o is high.
- R13: cls_o reports the cycle class with this priority: 3 for I/O (io_q_i), then 0 for instruction fetch (sync_q_i), then 1 for address fetch (ind_q_i), and 2 for a data fetch otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Map entry write strobe |
| cfg_idx_i | input | 4 | Map entry index |
| cfg_val_i | input | 1 | Map entry value (1 = RAM) |
| sync_q_i | input | 1 | Instruction fetch qualifier |
| cpu_q_i | input | 1 | Processor cycle qualifier |
| mon_q_i | input | 1 | Monitor cycle qualifier |
| mem_valid_i | input | 1 | Memory bus data valid |
| ind_q_i | input | 1 | Address (indirect) fetch qualifier |
| io_q_i | input | 1 | I/O cycle qualifier |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Cycle address |
| opt_fit_i | input | 1 | Option board fitted |
| ram_en_o | output | 1 | Option RAM enable |
| rom_sel_o | output | 1 | ROM select / RAM inhibit |
| opt_n_o | output | 1 | Option present, active low |
| prog_rom_en_o | output | 1 | System programming ROM window enable |
| cart_en_o | output | 1 | Cartridge ROM window enable |
| cls_o | output | 2 | Cycle class |

## Verification
Directed cycles set up the instruction tracker with a fetch from ROM and then with a fetch from RAM. They then issue data reads and writes into the tracked region and into other regions, which separates the own-region ROM rule from plain map lookup and from the rule that writes follow the map. Further cases probe the exclusion boundary at 0x07FF/0x0800, the half boundary, and the window edges at 0x53FF/0x5400 and 0x5FFF/0x6000. Each of these is tried with the map bit set and clear, so that address decoding is told apart from map lookup. Random qualifier combinations mixed with map writes cover the class priority, and they check that a map write only takes effect at the next edge.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    CYC_IFETCH = 2'd0,
    CYC_AFETCH = 2'd1,
    CYC_DFETCH = 2'd2,
    CYC_IO     = 2'd3
  } cyc_e;

  typedef struct packed {
    logic valid;
    cyc_e cls;
    logic wr;
  } cyc_t;
endpackage

// File: rtl/ovl_classify.sv
module ovl_classify
  import ovl_pkg::*;
(
  input  logic sync_q_i,
  input  logic cpu_q_i,
  input  logic mon_q_i,
  input  logic mem_valid_i,
  input  logic ind_q_i,
  input  logic io_q_i,
  input  logic wr_i,
  output cyc_t cyc_o
);
  always_comb begin
    cyc_o.valid = mem_valid_i && (cpu_q_i || mon_q_i);
    cyc_o.wr    = wr_i;
    if (io_q_i)        cyc_o.cls = CYC_IO;
    else if (sync_q_i) cyc_o.cls = CYC_IFETCH;
    else if (ind_q_i)  cyc_o.cls = CYC_AFETCH;
    else               cyc_o.cls = CYC_DFETCH;
  end
endmodule

// File: rtl/ovl_map.sv
module ovl_map #(
  parameter int unsigned RW = 4,
  parameter int unsigned NR = 1 << RW,
  parameter logic [NR-1:0] RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic          wr_val_i,
  input  logic [RW-1:0] rd_idx_i,
  output logic          rd_bit_o,
  output logic [NR-1:0] map_o
);
  logic [NR-1:0] map_q;

  for (genvar k = 0; k < NR; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 map_q[k] <= RST[k];
      else if (we_i && wr_idx_i == RW'(k))         map_q[k] <= wr_val_i;
    end
  end

  assign rd_bit_o = map_q[rd_idx_i];
  assign map_o    = map_q;
endmodule

// File: rtl/ovl_ins_trk.sv
module ovl_ins_trk #(
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [RW-1:0] rgn_i,
  input  logic          rom_i,
  output logic [RW-1:0] rgn_o,
  output logic          rom_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_o <= '0;
      rom_o <= 1'b0;
    end else if (cap_i) begin
      rgn_o <= rgn_i;
      rom_o <= rom_i;
    end
  end
endmodule

// File: rtl/ovl_win_dec.sv
module ovl_win_dec #(
  parameter int unsigned AW     = 16,
  parameter int unsigned WIN_W  = 10,
  parameter int unsigned N_CART = 3,
  parameter logic [AW-1:0] PROG_BASE = 16'h5000
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic          prog_o,
  output logic          cart_o
);
  localparam int unsigned TW = AW - WIN_W;
  localparam logic [TW-1:0] TAG = PROG_BASE[AW-1:WIN_W];

  logic [TW-1:0]     tag;
  logic [N_CART-1:0] hit;

  assign tag = addr_i[AW-1:WIN_W];

  for (genvar k = 0; k < N_CART; k++) begin : g_cart
    assign hit[k] = (tag == TW'(TAG + TW'(k + 1)));
  end

  assign prog_o = en_i && (tag == TAG);
  assign cart_o = en_i && (|hit);
endmodule

// File: rtl/ovl_sel.sv
module ovl_sel
  import ovl_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned RW = 4,
  parameter logic [AW-1:0] EXCL_LIM  = 16'h0800,
  parameter logic [AW-1:0] PROG_BASE = 16'h5000,
  parameter int unsigned WIN_W  = 10,
  parameter int unsigned N_CART = 3,
  parameter logic [(1<<RW)-1:0] MAP_RST = 16'h00F0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [RW-1:0] cfg_idx_i,
  input  logic          cfg_val_i,
  input  logic          sync_q_i,
  input  logic          cpu_q_i,
  input  logic          mon_q_i,
  input  logic          mem_valid_i,
  input  logic          ind_q_i,
  input  logic          io_q_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          opt_fit_i,
  output logic          ram_en_o,
  output logic          rom_sel_o,
  output logic          opt_n_o,
  output logic          prog_rom_en_o,
  output logic          cart_en_o,
  output logic [1:0]    cls_o
);
  localparam int unsigned NR = 1 << RW;

  cyc_t          cyc;
  logic [NR-1:0] map_q;
  logic          map_bit;
  logic [RW-1:0] rgn;
  logic [RW-1:0] trk_rgn;
  logic          trk_rom;
  logic          low_half;
  logic          excl;
  logic          ram_pick;
  logic          own_rom;
  logic          trk_cap;

  assign rgn      = addr_i[AW-1 -: RW];
  assign low_half = !addr_i[AW-1];
  assign excl     = low_half && (addr_i < EXCL_LIM);

  ovl_classify i_cls (
    .sync_q_i    (sync_q_i),
    .cpu_q_i     (cpu_q_i),
    .mon_q_i     (mon_q_i),
    .mem_valid_i (mem_valid_i),
    .ind_q_i     (ind_q_i),
    .io_q_i      (io_q_i),
    .wr_i        (wr_i),
    .cyc_o       (cyc)
  );

  ovl_map #(.RW(RW), .NR(NR), .RST(MAP_RST)) i_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wr_idx_i (cfg_idx_i),
    .wr_val_i (cfg_val_i),
    .rd_idx_i (rgn),
    .rd_bit_o (map_bit),
    .map_o    (map_q)
  );

  // ROM-resident code reading its own region gets its constants from ROM
  assign own_rom = trk_rom && (trk_rgn == rgn);

  always_comb begin
    ram_pick = 1'b0;
    if (opt_fit_i && cyc.valid && low_half && !excl) begin
      unique case (cyc.cls)
        CYC_IFETCH, CYC_AFETCH: ram_pick = map_bit;
        CYC_DFETCH:             ram_pick = map_bit && (cyc.wr || !own_rom);
        default:                ram_pick = 1'b0;
      endcase
    end
  end

  assign trk_cap = opt_fit_i && cyc.valid && (cyc.cls == CYC_IFETCH);

  ovl_ins_trk #(.RW(RW)) i_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (trk_cap),
    .rgn_i  (rgn),
    .rom_i  (low_half && !ram_pick),
    .rgn_o  (trk_rgn),
    .rom_o  (trk_rom)
  );

  ovl_win_dec #(
    .AW(AW), .WIN_W(WIN_W), .N_CART(N_CART), .PROG_BASE(PROG_BASE)
  ) i_win (
    .addr_i (addr_i),
    .en_i   (opt_fit_i && !ram_pick),
    .prog_o (prog_rom_en_o),
    .cart_o (cart_en_o)
  );

  assign ram_en_o  = ram_pick;
  assign rom_sel_o = !ram_pick;
  assign opt_n_o   = !opt_fit_i;
  assign cls_o     = cyc.cls;
endmodule

// File: rtl/ovl_sel_chk.sv
module ovl_sel_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned RW = 4,
  parameter logic [AW-1:0] EXCL_LIM = 16'h0800
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [RW-1:0]      cfg_idx_i,
  input logic               cfg_val_i,
  input logic               cpu_q_i,
  input logic               mon_q_i,
  input logic               mem_valid_i,
  input logic               io_q_i,
  input logic               opt_fit_i,
  input logic [AW-1:0]      addr_i,
  input logic               ram_en_o,
  input logic               rom_sel_o,
  input logic               opt_n_o,
  input logic               prog_rom_en_o,
  input logic [(1<<RW)-1:0] map_q
);
  assert_map_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> map_q[$past(cfg_idx_i)] == $past(cfg_val_i));

  assert_ram_needs_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> map_q[addr_i[AW-1 -: RW]]);

  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < EXCL_LIM) |-> !ram_en_o);

  assert_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[AW-1] |-> !ram_en_o);

  assert_io_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_q_i |-> !ram_en_o);

  assert_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> mem_valid_i && (cpu_q_i || mon_q_i));

  assert_absent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt_fit_i |-> opt_n_o && !ram_en_o);

  assert_prog_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_rom_en_o |-> opt_fit_i && rom_sel_o);
endmodule

bind ovl_sel ovl_sel_chk #(.AW(AW), .RW(RW), .EXCL_LIM(EXCL_LIM)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_idx_i     (cfg_idx_i),
  .cfg_val_i     (cfg_val_i),
  .cpu_q_i       (cpu_q_i),
  .mon_q_i       (mon_q_i),
  .mem_valid_i   (mem_valid_i),
  .io_q_i        (io_q_i),
  .opt_fit_i     (opt_fit_i),
  .addr_i        (addr_i),
  .ram_en_o      (ram_en_o),
  .rom_sel_o     (rom_sel_o),
  .opt_n_o       (opt_n_o),
  .prog_rom_en_o (prog_rom_en_o),
  .map_q         (map_q)
);

// File: tb/test_ovl_sel.sv
`timescale 1ns/1ps
module test_ovl_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_val = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        sync_q = 0, cpu_q = 0, mon_q = 0, mvalid = 0, ind_q = 0, io_q = 0, wr = 0, fit = 0;
  logic [15:0] addr = '0;
  logic        ram_en, rom_sel, opt_n, prog_en, cart_en;
  logic [1:0]  cls;

  int unsigned n_chk = 0, n_err = 0;

  logic [15:0] m_map;
  logic [3:0]  m_rgn;
  logic        m_rom;

  always #2 clk = ~clk;

  ovl_sel i_ovl_sel (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_val_i(cfg_val),
    .sync_q_i(sync_q), .cpu_q_i(cpu_q), .mon_q_i(mon_q), .mem_valid_i(mvalid), .ind_q_i(ind_q),
    .io_q_i(io_q), .wr_i(wr), .addr_i(addr), .opt_fit_i(fit),
    .ram_en_o(ram_en), .rom_sel_o(rom_sel), .opt_n_o(opt_n), .prog_rom_en_o(prog_en),
    .cart_en_o(cart_en), .cls_o(cls)
  );

  function automatic logic [1:0] f_cls(input logic io, input logic sy, input logic ind);
    if (io) return 2'd3;
    if (sy) return 2'd0;
    if (ind) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic f_ram(input logic [1:0] c, input logic valid, input logic w,
                                 input logic f, input logic [15:0] a);
    logic b;
    if (!f || !valid || a[15] || a < 16'h0800 || c == 2'd3) return 1'b0;
    b = m_map[a[15:12]];
    if (c == 2'd2 && !w && m_rom && m_rgn == a[15:12]) return 1'b0;
    return b;
  endfunction

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s addr=%h actual=%0d expected=%0d", req, what, addr, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic cp, input logic mn, input logic mv,
                      input logic in, input logic i_o, input logic w, input logic f,
                      input logic [15:0] a, input logic we, input logic [3:0] idx,
                      input logic v, input string req);
    logic [1:0] ec;
    logic       er, valid, win_en;
    @(negedge clk);
    sync_q = s; cpu_q = cp; mon_q = mn; mvalid = mv; ind_q = in; io_q = i_o; wr = w;
    fit = f; addr = a; cfg_we = we; cfg_idx = idx; cfg_val = v;
    #1;
    valid  = mv && (cp || mn);
    ec     = f_cls(i_o, s, in);
    er     = f_ram(ec, valid, w, f, a);
    win_en = f && !er;
    chk(req, "ram_en",  {3'b0, ram_en},  {3'b0, er});
    chk(req, "rom_sel", {3'b0, rom_sel}, {3'b0, !er});
    chk(req, "cls",     {2'b0, cls},     {2'b0, ec});
    chk(req, "opt_n",   {3'b0, opt_n},   {3'b0, !f});
    chk(req, "prog_en", {3'b0, prog_en}, {3'b0, win_en && a[15:10] == 6'b010100});
    chk(req, "cart_en", {3'b0, cart_en},
        {3'b0, win_en && a[15:12] == 4'h5 && a[11:10] != 2'b00});
    if (we) m_map[idx] = v;
    if (f && valid && ec == 2'd0) begin
      m_rgn = a[15:12];
      m_rom = !a[15] && !er;
    end
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    step(0, 1, 0, 1, 0, 0, 0, 1, a, 0, 4'd0, 0, req);
  endtask
  task automatic wrc(input logic [15:0] a, input string req);
    step(0, 1, 0, 1, 0, 0, 1, 1, a, 0, 4'd0, 0, req);
  endtask
  task automatic ifx(input logic [15:0] a, input string req);
    step(1, 1, 0, 1, 0, 0, 0, 1, a, 0, 4'd0, 0, req);
  endtask
  task automatic setm(input logic [3:0] idx, input logic v, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 1, idx, v, req);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    m_map = 16'h00F0; m_rgn = '0; m_rom = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset map and empty tracker
    rd(16'h4100, "R1");
    rd(16'h2100, "R1");
    // R2 map write then lookup
    setm(4'd2, 1, "R2");
    rd(16'h2100, "R2");
    setm(4'd4, 0, "R2");
    rd(16'h4100, "R2");
    // R3 exclusion boundary with region 0 mapped to RAM
    setm(4'd0, 1, "R3");
    rd(16'h07FF, "R3");
    rd(16'h0800, "R3");
    // R4 upper half
    setm(4'd9, 1, "R4");
    rd(16'h9000, "R4");
    rd(16'h7FFF, "R4");
    // R5 I/O cycle
    step(0, 1, 0, 1, 0, 1, 0, 1, 16'h6000, 0, 4'd0, 0, "R5");
    // R6 qualifiers missing
    step(0, 1, 0, 0, 0, 0, 0, 1, 16'h6000, 0, 4'd0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 0, 1, 16'h6000, 0, 4'd0, 0, "R6");
    step(0, 0, 1, 1, 0, 0, 0, 1, 16'h6000, 0, 4'd0, 0, "R6");
    // R7 write into ROM region ignored
    wrc(16'h3000, "R7");
    wrc(16'h2000, "R7");
    // R8 ROM code reading its own region
    setm(4'd6, 0, "R8");
    ifx(16'h6010, "R8");
    setm(4'd6, 1, "R8");
    rd(16'h6020, "R8");
    rd(16'h7020, "R8");
    wrc(16'h6020, "R7");
    ifx(16'h7000, "R9");
    rd(16'h6020, "R8");
    ifx(16'h8000, "R8");
    rd(16'h7000, "R8");
    // R9 address fetch follows map
    step(0, 1, 0, 1, 1, 0, 0, 1, 16'h2400, 0, 4'd0, 0, "R9");
    step(0, 1, 0, 1, 1, 0, 0, 1, 16'h3400, 0, 4'd0, 0, "R9");
    // R10 option absent
    step(0, 1, 0, 1, 0, 0, 0, 0, 16'h5000, 0, 4'd0, 0, "R10");
    step(0, 1, 0, 1, 0, 0, 0, 0, 16'h6000, 0, 4'd0, 0, "R10");
    // R11 R12 windows
    setm(4'd5, 0, "R11");
    rd(16'h5000, "R11");
    rd(16'h53FF, "R11");
    rd(16'h5400, "R12");
    rd(16'h5C00, "R12");
    rd(16'h5FFF, "R12");
    rd(16'h4FFF, "R12");
    setm(4'd5, 1, "R11");
    rd(16'h5000, "R11");
    rd(16'h5800, "R12");
    // R13 class priority
    step(1, 1, 0, 1, 1, 1, 0, 1, 16'h2000, 0, 4'd0, 0, "R13");
    step(1, 1, 0, 1, 1, 0, 0, 1, 16'h2000, 0, 4'd0, 0, "R13");
    step(0, 1, 0, 1, 1, 0, 1, 1, 16'h2000, 0, 4'd0, 0, "R13");
    // random mix
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom();
      a = $urandom();
      if (r[20]) a[15] = 1'b0;
      step(r[0] & r[1], r[2], r[3], r[4] | r[5], r[6] & r[7], r[8] & r[9] & r[10],
           r[11], r[12] | r[13] | r[14], a, r[15] & r[16] & r[17], r[24:21], r[25], "R13");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule